// File: doc/BRIEF.md
# Multi-Lane Converter Sample Buffer

This block holds converter results in four independent circular queues of sixteen entries each. A sample producer pushes results into a chosen queue. The register bus drains a queue by reading that queue's data register, and that read removes the entry. Each queue also has a packed status word. The word shows where the next read and the next write will land, and whether the queue is empty or full.

Two misuse flags are kept for each queue, and both are sticky. One records a push that was dropped because the queue was full. The other records a read of an empty queue. Software clears them by writing ones.

A trigger input stands in for a real conversion. When sequencer 0 is active, each cycle with the trigger high does three things:
- it advances a linear-congruential noise generator;
- it pushes a small pseudo-random sample into queue 0;
- it raises raw interrupt bit 0, which a mask register gates onto the interrupt output.

Top module: `sample_fifo_bank`

## Requirements
- R1: After reset, every queue's status word reads 0x100. The input-select and control registers, the overflow and underflow registers, the raw interrupt register and the interrupt output are all zero.
- R2: The status word of queue n sits at 0x4C + n*0x20. Its fields are read pointer in bits 3:0, write pointer in bits 7:4, empty at bit 8 and full at bit 12. An accepted push advances the write pointer modulo 16 and clears empty.
- R3: A push that makes the write pointer equal the read pointer sets full. A push into a full queue is dropped, leaves the status word unchanged and sets bit n of the overflow register at 0x10.
- R4: A bus read of 0x48 + n*0x20 returns the entry at the read pointer and removes it in that same cycle. The read pointer advances modulo 16, full clears, and empty sets when the read pointer reaches the write pointer. Entries come out in push order.
- R5: A read of an empty queue sets bit n of the underflow register at 0x18 and leaves both pointers unchanged.
- R6: Writing a 1 to a bit of 0x10 or 0x18 clears that bit. Writing a 0 leaves it set.
- R7: When a push and a read hit the same queue in one cycle, each is judged against the queue's state at the start of that cycle. On an empty queue the read underflows and the push is kept. On a full queue the read succeeds and the push is dropped as an overflow. Otherwise both succeed.
- R8: A trigger cycle has no effect unless bit 0 of the active register at 0x00 is set. An accepted trigger does three things. It steps the 32-bit noise state (starting at 0) to state*314159+1. It pushes 0x200 plus bits 18:16 of the new state into queue 0. It sets bit 0 of the raw interrupt register at 0x04.
- R9: The interrupt output is high exactly when raw AND mask (mask at 0x08) is nonzero. Reading 0x0C gives raw AND mask. Writing a 1 to a bit of 0x0C clears that raw bit.
- R10: The input-select register at 0x40 + n*0x20 keeps only the bits of 0x33333333 from a write. The control register at 0x44 + n*0x20 keeps the low 8 bits.
- R11: When an accepted trigger and a producer push to queue 0 fall in the same cycle, the trigger's sample is stored and the producer's sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on a data offset) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| smp_valid | input | 1 | Producer push request |
| smp_lane | input | 2 | Target queue of the producer push |
| smp_data | input | 16 | Producer sample |
| trig | input | 1 | Conversion trigger, one per high cycle |
| irq | output | 1 | Masked interrupt |

## Verification
A pointer or flag that goes wrong shows up on the status word at the very next bus read. From there it spreads to the data stream. Entries come out of order, a stale value reappears where a fresh one is expected, or a sticky error flag appears one cycle after the bad push or read. A noise generator that steps when it should not is caught by the very next accepted trigger, because the stored sample no longer matches the expected sequence. The bench therefore checks the status word after each step, and the data values over a full wrap of the pointers.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam logic [7:0] OFS_ACTIVE = 8'h00;
  localparam logic [7:0] OFS_RAW    = 8'h04;
  localparam logic [7:0] OFS_MASK   = 8'h08;
  localparam logic [7:0] OFS_ICLR   = 8'h0C;
  localparam logic [7:0] OFS_OVF    = 8'h10;
  localparam logic [7:0] OFS_UNF    = 8'h18;

  localparam logic [31:0] LANE_BASE   = 32'h40;
  localparam int unsigned LANE_STRIDE = 32;

  localparam logic [4:0] SUB_SEL  = 5'h00;
  localparam logic [4:0] SUB_CTRL = 5'h04;
  localparam logic [4:0] SUB_DATA = 5'h08;
  localparam logic [4:0] SUB_STAT = 5'h0C;

  localparam logic [31:0] SEL_KEEP   = 32'h3333_3333;
  localparam logic [31:0] LCG_MUL    = 32'd314159;
  localparam logic [31:0] LCG_INC    = 32'd1;
  localparam logic [31:0] NOISE_BASE = 32'h200;

  // Packs the queue status: rd ptr 3:0, wr ptr 7:4, empty 8, full 12.
  function automatic logic [31:0] pack_status(input logic [3:0] rd_ptr,
                                              input logic [3:0] wr_ptr,
                                              input logic       is_empty,
                                              input logic       is_full);
    return {19'd0, is_full, 3'd0, is_empty, wr_ptr, rd_ptr};
  endfunction
endpackage

// File: rtl/sfb_lane.sv
module sfb_lane #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] out_data,
  output logic [3:0]    rd_ptr_o,
  output logic [3:0]    wr_ptr_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          push_err,
  output logic          pop_err
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d, wr_inc, rd_inc;
  logic          empty_q, empty_d, full_q, full_d;
  logic          push_ok, pop_ok;

  always_comb begin
    wr_inc  = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    rd_inc  = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    push_ok = push_req && !full_q;
    pop_ok  = pop_req && !empty_q;
    wr_d    = push_ok ? wr_inc : wr_q;
    rd_d    = pop_ok ? rd_inc : rd_q;
    empty_d = empty_q;
    full_d  = full_q;
    if (push_ok && !pop_ok) begin
      empty_d = 1'b0;
      full_d  = (wr_inc == rd_q);
    end else if (pop_ok && !push_ok) begin
      full_d  = 1'b0;
      empty_d = (rd_inc == wr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      empty_q <= empty_d;
      full_q  <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= push_data;
  end

  assign out_data = mem_q[rd_q];
  assign rd_ptr_o = 4'(rd_q);
  assign wr_ptr_o = 4'(wr_q);
  assign empty_o  = empty_q;
  assign full_o   = full_q;
  assign push_err = push_req && full_q;
  assign pop_err  = pop_req && empty_q;

  // R3: full and empty never both set
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));
  // R3: a push into a full queue does not move the write pointer
  a_r3_drop_holds_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full_q) |=> $stable(wr_q));
  // R4: a successful read moves the read pointer
  a_r4_pop_moves_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty_q) |=> (rd_q != $past(rd_q)));
  // R5: a read of an empty queue leaves the read pointer
  a_r5_underflow_holds_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty_q) |=> $stable(rd_q));
endmodule

// File: rtl/sfb_noise.sv
module sfb_noise
  import sfb_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [DW-1:0] smp_o
);
  logic [31:0] st_q, st_d, nxt;

  always_comb begin
    nxt  = st_q * LCG_MUL + LCG_INC;
    st_d = adv ? nxt : st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign smp_o = DW'(NOISE_BASE + {29'd0, nxt[18:16]});

  // R8: noise state only moves on an accepted trigger
  a_r8_noise_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(st_q));
endmodule

// File: rtl/sample_fifo_bank.sv
module sample_fifo_bank
  import sfb_pkg::*;
#(
  parameter int unsigned N_LANE = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DW     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      smp_valid,
  input  logic [$clog2(N_LANE)-1:0] smp_lane,
  input  logic [DW-1:0]             smp_data,
  input  logic                      trig,
  output logic                      irq
);
  localparam int unsigned LW = $clog2(N_LANE);
  localparam logic [31:0] LANE_SPAN = 32'(N_LANE * LANE_STRIDE);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // Address decode
  logic [31:0]   addr32, lane_off;
  logic          lane_hit;
  logic [LW-1:0] lane_idx;
  logic [4:0]    sub;
  always_comb begin
    addr32   = {24'd0, bus_addr};
    lane_off = addr32 - LANE_BASE;
    lane_hit = (addr32 >= LANE_BASE) && (lane_off < LANE_SPAN);
    lane_idx = lane_off[5 +: LW];
    sub      = bus_addr[4:0];
  end

  // Global registers
  logic [N_LANE-1:0] act_q, act_d, mask_q, mask_d, raw_q, raw_d;
  logic [N_LANE-1:0] ovf_q, ovf_d, unf_q, unf_d;
  logic [N_LANE-1:0] push_err, pop_err;
  logic [N_LANE-1:0] clr_bits;
  logic              trig_ok;
  logic [DW-1:0]     noise_smp;

  assign trig_ok  = trig && act_q[0];
  assign clr_bits = bus_wdata[N_LANE-1:0];

  sfb_noise #(.DW(DW)) u_noise (
    .clk   (clk),
    .rst_n (rst_i_n),
    .adv   (trig_ok),
    .smp_o (noise_smp)
  );

  // Per-lane queues and registers
  logic [DW-1:0] lane_out [N_LANE];
  logic [31:0]   lane_stat [N_LANE];
  logic [31:0]   sel_q [N_LANE];
  logic [7:0]    ctrl_q [N_LANE];

  for (genvar n = 0; n < N_LANE; n++) begin : g_lane
    logic          push_req, pop_req, hit;
    logic [DW-1:0] push_data;
    logic [3:0]    rdp, wrp;
    logic          emp, ful;
    logic [31:0]   sel_d;
    logic [7:0]    ctrl_d;

    assign hit = lane_hit && (lane_idx == LW'(n));

    if (n == 0) begin : g_trig
      assign push_req  = trig_ok || (smp_valid && (smp_lane == LW'(n)));
      assign push_data = trig_ok ? noise_smp : smp_data;
    end else begin : g_plain
      assign push_req  = smp_valid && (smp_lane == LW'(n));
      assign push_data = smp_data;
    end
    assign pop_req = bus_rd && hit && (sub == SUB_DATA);

    sfb_lane #(.DEPTH(DEPTH), .DW(DW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .push_req  (push_req),
      .push_data (push_data),
      .pop_req   (pop_req),
      .out_data  (lane_out[n]),
      .rd_ptr_o  (rdp),
      .wr_ptr_o  (wrp),
      .empty_o   (emp),
      .full_o    (ful),
      .push_err  (push_err[n]),
      .pop_err   (pop_err[n])
    );
    assign lane_stat[n] = pack_status(rdp, wrp, emp, ful);

    always_comb begin
      sel_d  = sel_q[n];
      ctrl_d = ctrl_q[n];
      if (bus_wr && hit && (sub == SUB_SEL))  sel_d  = bus_wdata & SEL_KEEP;
      if (bus_wr && hit && (sub == SUB_CTRL)) ctrl_d = bus_wdata[7:0];
    end

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
        sel_q[n]  <= '0;
        ctrl_q[n] <= '0;
      end else begin
        sel_q[n]  <= sel_d;
        ctrl_q[n] <= ctrl_d;
      end
    end
  end

  // Next state of global registers
  always_comb begin
    logic g_wr;
    g_wr   = bus_wr && !lane_hit;
    act_d  = (g_wr && bus_addr == OFS_ACTIVE) ? clr_bits : act_q;
    mask_d = (g_wr && bus_addr == OFS_MASK) ? clr_bits : mask_q;
    raw_d  = raw_q & ~((g_wr && bus_addr == OFS_ICLR) ? clr_bits : '0);
    raw_d[0] = raw_d[0] | trig_ok;
    ovf_d  = (ovf_q & ~((g_wr && bus_addr == OFS_OVF) ? clr_bits : '0)) | push_err;
    unf_d  = (unf_q & ~((g_wr && bus_addr == OFS_UNF) ? clr_bits : '0)) | pop_err;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      act_q  <= '0;
      mask_q <= '0;
      raw_q  <= '0;
      ovf_q  <= '0;
      unf_q  <= '0;
    end else begin
      act_q  <= act_d;
      mask_q <= mask_d;
      raw_q  <= raw_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (lane_hit) begin
      case (sub)
        SUB_SEL:  bus_rdata = sel_q[lane_idx];
        SUB_CTRL: bus_rdata = {24'd0, ctrl_q[lane_idx]};
        SUB_DATA: bus_rdata = 32'(lane_out[lane_idx]);
        SUB_STAT: bus_rdata = lane_stat[lane_idx];
        default:  bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        OFS_ACTIVE: bus_rdata = 32'(act_q);
        OFS_RAW:    bus_rdata = 32'(raw_q);
        OFS_MASK:   bus_rdata = 32'(mask_q);
        OFS_ICLR:   bus_rdata = 32'(raw_q & mask_q);
        OFS_OVF:    bus_rdata = 32'(ovf_q);
        OFS_UNF:    bus_rdata = 32'(unf_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(raw_q & mask_q);

  // R8: an accepted trigger leaves raw bit 0 set
  a_r8_accept_sets_raw: assert property (@(posedge clk) disable iff (!rst_i_n)
    trig_ok |=> raw_q[0]);
  // R5: every underflowing read leaves its sticky bit set
  a_r5_unf_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|pop_err) |=> ((unf_q & $past(pop_err)) == $past(pop_err)));
  // R3: every dropped push leaves its sticky bit set
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|push_err) |=> ((ovf_q & $past(push_err)) == $past(push_err)));
endmodule

// File: tb/tb_sample_fifo_bank.sv
module tb_sample_fifo_bank;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        smp_valid;
  logic [1:0]  smp_lane;
  logic [15:0] smp_data;
  logic        trig;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] m_noise = 32'd0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sample_fifo_bank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .smp_valid (smp_valid),
    .smp_lane  (smp_lane),
    .smp_data  (smp_data),
    .trig      (trig),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_sample();
    m_noise = m_noise * 32'd314159 + 32'd1;
    return 32'h200 + {29'd0, m_noise[18:16]};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic [1:0] l, input logic [15:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_lane = l; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic push_and_read(input logic [1:0] l, input logic [15:0] d, output logic [31:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_lane = l; smp_data = d;
    bus_addr = 8'h48 + 8'(l) * 8'h20; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    smp_valid = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int l = 0; l < 4; l++) begin
      rd(8'h4C + 8'(l) * 8'h20, v); chk("R1 status", v, 32'h100);
      rd(8'h40 + 8'(l) * 8'h20, v); chk("R1 select", v, 32'h0);
      rd(8'h44 + 8'(l) * 8'h20, v); chk("R1 control", v, 32'h0);
    end
    rd(8'h10, v); chk("R1 overflow", v, 32'h0);
    rd(8'h18, v); chk("R1 underflow", v, 32'h0);
    rd(8'h04, v); chk("R1 raw", v, 32'h0);
  endtask

  task automatic t_fill();
    logic [31:0] v;
    push(2'd2, 16'h100);
    rd(8'h8C, v); chk("R2 one push", v, 32'h010);
    for (int i = 1; i < 16; i++) push(2'd2, 16'(16'h100 + i));
    rd(8'h8C, v); chk("R3 full", v, 32'h1000);
    push(2'd2, 16'hDEAD);
    rd(8'h8C, v); chk("R3 drop keeps status", v, 32'h1000);
    rd(8'h10, v); chk("R3 overflow bit", v, 32'h4);
  endtask

  task automatic t_drain();
    logic [31:0] v;
    rd(8'h88, v); chk("R4 first entry", v, 32'h100);
    rd(8'h8C, v); chk("R4 status after pop", v, 32'h001);
    for (int i = 1; i < 16; i++) begin
      rd(8'h88, v); chk("R4 order", v, 32'h100 + 32'(i));
    end
    rd(8'h8C, v); chk("R4 empty after wrap", v, 32'h100);
    rd(8'h88, v);
    rd(8'h8C, v); chk("R5 pointers held", v, 32'h100);
    rd(8'h18, v); chk("R5 underflow bit", v, 32'h4);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(8'h10, 32'h0); rd(8'h10, v); chk("R6 overflow zero write", v, 32'h4);
    wr(8'h10, 32'h4); rd(8'h10, v); chk("R6 overflow cleared", v, 32'h0);
    wr(8'h18, 32'h0); rd(8'h18, v); chk("R6 underflow zero write", v, 32'h4);
    wr(8'h18, 32'h4); rd(8'h18, v); chk("R6 underflow cleared", v, 32'h0);
  endtask

  task automatic t_simul();
    logic [31:0] v;
    push_and_read(2'd1, 16'h00AB, v);
    rd(8'h18, v); chk("R7 empty read underflows", v, 32'h2);
    rd(8'h6C, v); chk("R7 empty push kept", v, 32'h010);
    rd(8'h68, v); chk("R7 kept value", v, 32'hAB);
    for (int i = 0; i < 16; i++) push(2'd1, 16'(i));
    rd(8'h6C, v); chk("R7 full status", v, 32'h1011);
    push_and_read(2'd1, 16'h00EE, v); chk("R7 full read value", v, 32'h0);
    rd(8'h6C, v); chk("R7 full push dropped", v, 32'h012);
    rd(8'h10, v); chk("R7 overflow", v, 32'h2);
    for (int i = 1; i < 16; i++) rd(8'h68, v);
    chk("R7 last entry not dropped one", v, 32'hF);
    push(2'd3, 16'h11);
    push_and_read(2'd3, 16'h22, v); chk("R7 both ok read", v, 32'h11);
    rd(8'hAC, v); chk("R7 both ok status", v, 32'h021);
    rd(8'hA8, v); chk("R7 both ok next", v, 32'h22);
    wr(8'h10, 32'hF); wr(8'h18, 32'hF);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    logic [31:0] e [3];
    pulse_trig();
    rd(8'h4C, v); chk("R8 inactive ignored status", v, 32'h100);
    rd(8'h04, v); chk("R8 inactive raw", v, 32'h0);
    wr(8'h00, 32'h1);
    for (int i = 0; i < 3; i++) begin
      pulse_trig();
      e[i] = next_sample();
    end
    rd(8'h04, v); chk("R8 raw set", v, 32'h1);
    rd(8'h4C, v); chk("R8 three pushes", v, 32'h030);
    for (int i = 0; i < 3; i++) begin
      rd(8'h48, v); chk("R8 noise sample", v, e[i]);
    end
  endtask

  task automatic t_irq();
    logic [31:0] v;
    chk("R9 masked off", {31'd0, irq}, 32'd0);
    rd(8'h0C, v); chk("R9 masked read zero", v, 32'h0);
    wr(8'h08, 32'h1);
    chk("R9 irq high", {31'd0, irq}, 32'd1);
    rd(8'h0C, v); chk("R9 masked read", v, 32'h1);
    wr(8'h0C, 32'h1);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);
    rd(8'h04, v); chk("R9 raw cleared", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'hA0, 32'hFFFF_FFFF); rd(8'hA0, v); chk("R10 select mask", v, 32'h3333_3333);
    wr(8'hA4, 32'h0000_1234); rd(8'hA4, v); chk("R10 control low byte", v, 32'h34);
  endtask

  task automatic t_prio();
    logic [31:0] v, e;
    @(negedge clk);
    trig = 1'b1; smp_valid = 1'b1; smp_lane = 2'd0; smp_data = 16'h55;
    @(negedge clk);
    trig = 1'b0; smp_valid = 1'b0;
    e = next_sample();
    rd(8'h4C, v); chk("R11 single entry", v, 32'h043);
    rd(8'h48, v); chk("R11 trigger sample wins", v, e);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    smp_valid = 1'b0; smp_lane = '0; smp_data = '0; trig = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_drain();
    t_w1c();
    t_simul();
    t_trigger();
    t_irq();
    t_regs();
    t_prio();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule